// File: doc/BRIEF.md
# Four-way virtually indexed, physically tagged data cache

This block is a first-level data cache that takes loads and stores addressed by virtual address. The set index and the byte position inside a line come from address bits below the page boundary, which translation never changes. The tag and data arrays can therefore be read while the virtual page number is sent out for translation in the same step. The physical page number that comes back is compared against the physical tag stored in each of the four ways. Any two virtual addresses that map to the same physical word land in the same set and match the same tag, so they share one cache location.

Misses are handled one at a time. The victim is the lowest-numbered invalid way, or else the least recently used way. If the victim holds modified data, the controller writes the whole line to the next level before it reads the new line. Stores use write-back and write-allocate. A load or store that misses completes only after the fill, and its response reports a miss. With the default parameters the cache holds 32 KB as 256 sets of four 32-byte lines, and pages are 8 KB.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and `resp_valid`, `tr_valid`, `mem_rd` and `mem_wr` are low, so the first access to any address misses.
- R2: Virtual address bits [12:5] select the set and bits [4:2] select the 32-bit word within the line, where word w occupies line bits [32w+31:32w]. Byte-enable bit b writes store-data bits [8b+7:8b] into the same bits of the word. A load returns the whole word.
- R3: While a request is in lookup, `tr_valid` is high and `tr_vpn` equals address bits [31:13]. In every cycle where `tr_ready` is low, the block neither responds nor starts a next-level transfer, and it retries the compare in the next cycle.
- R4: A hit is declared only when a valid way's stored tag equals `tr_ppn`. Two virtual addresses with the same low 13 bits that translate to the same physical page hit the same line and see the same data.
- R5: A load miss reads the whole line at physical address {ppn, index, 5'b0} and then responds with `resp_hit` = 0 and the requested word of the fetched line.
- R6: A store hit merges its bytes into the line and marks it dirty, with no next-level transfer.
- R7: A store miss first fetches the line, then merges the store into it and marks the line dirty. A later load returns the merged word.
- R8: When the victim of a miss is valid and dirty, a block write of its data to {stored tag, index, 5'b0} completes before the block read starts. A clean or invalid victim causes no write.
- R9: The victim is the lowest-numbered invalid way. If all ways are valid, it is the way whose last hit or fill is oldest.
- R10: Every access gets exactly one response, a one-cycle `resp_valid` pulse. `resp_hit` is 1 for a hit. `resp_rdata` carries the loaded word, or for a store the word after the merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address |
| req_be | input | 4 | Byte enables for a store |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Access hit without a fill |
| resp_rdata | output | 32 | Loaded or merged word |
| tr_valid | output | 1 | Translation requested |
| tr_vpn | output | 19 | Virtual page number to translate |
| tr_ready | input | 1 | Translation result valid this cycle |
| tr_ppn | input | 19 | Physical page number |
| mem_rd | output | 1 | Block read request, held until acknowledged |
| mem_wr | output | 1 | Block write request, held until acknowledged |
| mem_addr | output | 32 | Line-aligned physical address |
| mem_wdata | output | 256 | Line being written back |
| mem_ack | input | 1 | Transfer complete; read data valid |
| mem_rdata | input | 256 | Line returned by a block read |

## Verification
The hardest situation to reach from the ports is an eviction of a dirty line that chooses its victim by recency. For that, all four ways of one set must be valid, at least one must be modified, and the touch order must differ from the fill order. The stimulus maps virtual pages onto only eight physical pages, and most random addresses are confined to three sets, so sets fill and overflow within a few dozen accesses. It also draws page numbers from a range twice as large as the physical range, so virtual aliases hit the lines that other page numbers brought in. A directed sequence fills one set, touches its oldest line again, and then forces a fifth page into the set. A second directed sequence dirties a line before forcing it out, so that the ordered write-then-read on the memory port can be checked.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL
  } st_t;
endpackage

// File: rtl/vipt_way_ram.sv
module vipt_way_ram #(
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 19,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [TAG_W-1:0]  wtag,
  input  logic [LINE_W-1:0] wline,
  input  logic [IDX_W-1:0]  raddr,
  output logic [TAG_W-1:0]  rtag,
  output logic [LINE_W-1:0] rline
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [LINE_W-1:0] line_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[waddr]  <= wtag;
      line_mem[waddr] <= wline;
    end
    rtag  <= tag_mem[raddr];
    rline <= line_mem[raddr];
  end
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
  parameter int SETS = 256,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAY_W-1:0] lru_way,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [WAY_W-1:0] touch_way
);
  logic [WAY_W-1:0] age [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[touch_idx][w] <= '0;
        else if (age[touch_idx][w] < age[touch_idx][touch_way])
          age[touch_idx][w] <= age[touch_idx][w] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[rd_idx][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
  end

  // R9: a touched way becomes the most recent in its set
  p_mru_after_touch_r9: assert property (@(posedge clk) disable iff (rst)
    touch |=> age[$past(touch_idx)][$past(touch_way)] == '0);
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_pkg::*;
#(
  parameter int VADDR_W    = 32,
  parameter int PADDR_W    = 32,
  parameter int PAGE_BITS  = 13,
  parameter int WAYS       = 4,
  parameter int SETS       = 256,
  parameter int LINE_BYTES = 32,
  parameter int WORD_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [VADDR_W-1:0]          req_vaddr,
  input  logic [WORD_W/8-1:0]         req_be,
  input  logic [WORD_W-1:0]           req_wdata,
  output logic                        resp_valid,
  output logic                        resp_hit,
  output logic [WORD_W-1:0]           resp_rdata,
  output logic                        tr_valid,
  output logic [VADDR_W-PAGE_BITS-1:0] tr_vpn,
  input  logic                        tr_ready,
  input  logic [PADDR_W-PAGE_BITS-1:0] tr_ppn,
  output logic                        mem_rd,
  output logic                        mem_wr,
  output logic [PADDR_W-1:0]          mem_addr,
  output logic [LINE_BYTES*8-1:0]     mem_wdata,
  input  logic                        mem_ack,
  input  logic [LINE_BYTES*8-1:0]     mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WB_N   = WORD_W / 8;
  localparam int BSEL_W = $clog2(WB_N);
  localparam int WSEL_W = OFF_W - BSEL_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int TAG_W  = PADDR_W - PAGE_BITS;
  localparam int WAY_W  = $clog2(WAYS);

  generate
    if (IDX_W + OFF_W != PAGE_BITS) begin : g_bad_geometry
      $error("index plus offset must equal the page offset width");
    end
  endgenerate

  st_t               st;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] wsel_q;
  logic              wr_q;
  logic [WB_N-1:0]   be_q;
  logic [WORD_W-1:0] wdata_q;
  logic [TAG_W-1:0]  ppn_q;
  logic [WAY_W-1:0]  way_q;
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];

  logic              unused_lo;
  assign unused_lo = ^req_vaddr[BSEL_W-1:0];

  logic [IDX_W-1:0]  raddr;
  logic [TAG_W-1:0]  rd_tag  [WAYS];
  logic [LINE_W-1:0] rd_line [WAYS];
  logic [WAYS-1:0]   ram_we;
  logic [TAG_W-1:0]  wtag;
  logic [LINE_W-1:0] base_line, new_line, hit_line;
  logic [WAYS-1:0]   hit_vec;
  logic              hit_any;
  logic [WAY_W-1:0]  hit_way, vic_way, lru_way;
  logic              look_hit, fill_done, vic_dirty;
  logic [WORD_W-1:0] resp_word;

  assign req_ready = (st == ST_IDLE);
  assign tr_valid  = (st == ST_LOOK);
  assign raddr     = (st == ST_IDLE) ? req_vaddr[PAGE_BITS-1:OFF_W] : idx_q;

  // Way storage: read with the virtual index while translation runs
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign ram_we[w] = (look_hit && wr_q && hit_vec[w]) ||
                       (fill_done && way_q == WAY_W'(w));
    vipt_way_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_ram (
      .clk(clk), .we(ram_we[w]), .waddr(idx_q), .wtag(wtag), .wline(new_line),
      .raddr(raddr), .rtag(rd_tag[w]), .rline(rd_line[w]));
    assign hit_vec[w] = valid_q[idx_q][w] && (rd_tag[w] == tr_ppn);
  end

  always_comb begin
    hit_any  = |hit_vec;
    hit_way  = '0;
    hit_line = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) begin
        hit_way  = WAY_W'(w);
        hit_line = rd_line[w];
      end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    vic_way = lru_way;
    for (int w = 0; w < WAYS; w++)
      if (!found && !valid_q[idx_q][w]) begin
        vic_way = WAY_W'(w);
        found   = 1'b1;
      end
  end

  assign vic_dirty = valid_q[idx_q][vic_way] && dirty_q[idx_q][vic_way];
  assign look_hit  = (st == ST_LOOK) && tr_ready && hit_any;
  assign fill_done = (st == ST_FILL) && mem_ack;
  assign wtag      = (st == ST_FILL) ? ppn_q : tr_ppn;
  assign base_line = (st == ST_FILL) ? mem_rdata : hit_line;

  always_comb begin
    new_line = base_line;
    if (wr_q)
      for (int b = 0; b < WB_N; b++)
        if (be_q[b]) new_line[int'(wsel_q) * WORD_W + b * 8 +: 8] = wdata_q[b * 8 +: 8];
    resp_word = new_line[int'(wsel_q) * WORD_W +: WORD_W];
  end

  vipt_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst(rst), .rd_idx(idx_q), .lru_way(lru_way),
    .touch(look_hit || fill_done), .touch_idx(idx_q),
    .touch_way(fill_done ? way_q : hit_way));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (look_hit && wr_q) begin
      dirty_q[idx_q][hit_way] <= 1'b1;
    end else if (fill_done) begin
      valid_q[idx_q][way_q] <= 1'b1;
      dirty_q[idx_q][way_q] <= wr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      tr_vpn     <= '0;
      idx_q      <= '0;
      wsel_q     <= '0;
      wr_q       <= 1'b0;
      be_q       <= '0;
      wdata_q    <= '0;
      ppn_q      <= '0;
      way_q      <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          idx_q   <= req_vaddr[PAGE_BITS-1:OFF_W];
          wsel_q  <= req_vaddr[OFF_W-1:BSEL_W];
          wr_q    <= req_write;
          be_q    <= req_be;
          wdata_q <= req_wdata;
          tr_vpn  <= req_vaddr[VADDR_W-1:PAGE_BITS];
          st      <= ST_LOOK;
        end
        ST_LOOK: if (tr_ready) begin
          if (hit_any) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_rdata <= resp_word;
            st         <= ST_IDLE;
          end else begin
            ppn_q <= tr_ppn;
            way_q <= vic_way;
            if (vic_dirty) begin
              mem_wr    <= 1'b1;
              mem_addr  <= {rd_tag[vic_way], idx_q, {OFF_W{1'b0}}};
              mem_wdata <= rd_line[vic_way];
              st        <= ST_WB;
            end else begin
              mem_rd   <= 1'b1;
              mem_addr <= {tr_ppn, idx_q, {OFF_W{1'b0}}};
              st       <= ST_FILL;
            end
          end
        end
        ST_WB: if (mem_ack) begin
          mem_wr   <= 1'b0;
          mem_rd   <= 1'b1;
          mem_addr <= {ppn_q, idx_q, {OFF_W{1'b0}}};
          st       <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          mem_rd     <= 1'b0;
          resp_valid <= 1'b1;
          resp_hit   <= 1'b0;
          resp_rdata <= resp_word;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: physical tags in one set never match twice
  p_single_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK) |-> $onehot0(hit_vec));
  // R3: an unready translation freezes the lookup
  p_hold_on_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (tr_valid && !tr_ready) |=> (tr_valid && $stable(tr_vpn) && !resp_valid && !mem_rd && !mem_wr));
  // R8: never a read and a write at once; a write-back hands over to the fill
  p_one_transfer_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  p_wb_then_fill_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr) |-> mem_rd);
  // R5: a pending block read keeps its address
  p_read_held_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));
  // R10: response is a single-cycle strobe
  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
endmodule

// File: tb/vipt_dcache_test.sv
module vipt_dcache_test;
  localparam int LINES = 2048;
  localparam int LAT   = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst;
  logic         req_valid, req_ready, req_write;
  logic [31:0]  req_vaddr;
  logic [3:0]   req_be;
  logic [31:0]  req_wdata;
  logic         resp_valid, resp_hit;
  logic [31:0]  resp_rdata;
  logic         tr_valid, tr_ready;
  logic [18:0]  tr_vpn, tr_ppn;
  logic         mem_rd, mem_wr, mem_ack;
  logic [31:0]  mem_addr;
  logic [255:0] mem_wdata, mem_rdata;

  vipt_dcache uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_vaddr(req_vaddr), .req_be(req_be), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .tr_valid(tr_valid), .tr_vpn(tr_vpn), .tr_ready(tr_ready), .tr_ppn(tr_ppn),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int n_tests = 0, n_fail = 0;

  function automatic logic [18:0] ppn_of(input logic [18:0] vpn);
    return 19'((vpn * 5 + 3) & 7);
  endfunction

  function automatic logic [31:0] init_word(input int l, input int w);
    return 32'((l * 8 + w) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [31:0] va_of(input int vpn, input int set, input int w);
    return {19'(vpn), 8'(set), 3'(w), 2'b00};
  endfunction

  // Translation unit model
  int stall_req = 0, stall_cnt = 0;
  int stall_cycles = 0, stall_bad = 0;
  assign tr_ready = (stall_cnt == 0);
  assign tr_ppn   = ppn_of(tr_vpn);
  always @(posedge clk)
    if (req_valid && req_ready) stall_cnt <= stall_req;
    else if (tr_valid && stall_cnt > 0) stall_cnt <= stall_cnt - 1;
  always @(negedge clk)
    if (!rst && tr_valid && !tr_ready) begin
      stall_cycles++;
      if (mem_rd || mem_wr || resp_valid) stall_bad++;
    end

  // Next-level memory model with transfer log
  logic [255:0] bmem [LINES];
  logic [255:0] gmem [LINES];
  int mcnt = 0;
  int log_n = 0;
  bit log_wr [4];
  logic [31:0] log_addr [4];
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      mcnt <= 0;
    end else begin
      if (req_valid && req_ready) log_n <= 0;
      if ((mem_rd || mem_wr) && !mem_ack) begin
        if (mcnt == LAT) begin
          mem_ack <= 1'b1;
          mcnt    <= 0;
          if (mem_wr) bmem[mem_addr[15:5]] <= mem_wdata;
          else        mem_rdata <= bmem[mem_addr[15:5]];
          if (log_n < 4) begin
            log_wr[log_n]   <= mem_wr;
            log_addr[log_n] <= mem_addr;
            log_n           <= log_n + 1;
          end
        end else begin
          mcnt <= mcnt + 1;
        end
      end
    end
  end

  // Reference cache state
  int m_tag [256][4];
  bit m_val [256][4];
  bit m_dty [256][4];
  int m_stamp [256][4];
  int stamp = 0;

  task automatic check(input bit ok, input string r, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] va, input logic [3:0] be,
                        input logic [31:0] wd, input int stall);
    int set, w, ppn, pl, hw, vic, wb_line, s0, b0, guard, n_exp;
    bit exp_hit, exp_wb;
    logic [31:0] oldw, neww;
    set = int'(va[12:5]); w = int'(va[4:2]);
    ppn = int'(ppn_of(va[31:13])); pl = ppn * 256 + set;
    hw = -1; vic = -1; exp_wb = 0; wb_line = 0;
    for (int k = 0; k < 4; k++) if (m_val[set][k] && m_tag[set][k] == ppn) hw = k;
    exp_hit = (hw >= 0);
    if (!exp_hit) begin
      for (int k = 3; k >= 0; k--) if (!m_val[set][k]) vic = k;
      if (vic < 0) begin
        vic = 0;
        for (int k = 1; k < 4; k++) if (m_stamp[set][k] < m_stamp[set][vic]) vic = k;
      end
      exp_wb  = m_val[set][vic] && m_dty[set][vic];
      wb_line = m_tag[set][vic] * 256 + set;
      m_val[set][vic] = 1; m_tag[set][vic] = ppn; m_dty[set][vic] = 0;
      hw = vic;
    end
    if (wr) m_dty[set][hw] = 1;
    stamp++; m_stamp[set][hw] = stamp;
    oldw = gmem[pl][w*32 +: 32]; neww = oldw;
    for (int b = 0; b < 4; b++) if (be[b]) neww[b*8 +: 8] = wd[b*8 +: 8];
    if (wr) gmem[pl][w*32 +: 32] = neww;

    stall_req = stall; s0 = stall_cycles; b0 = stall_bad;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_vaddr = va; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    guard = 0;
    while (!resp_valid && guard < 300) begin @(negedge clk); guard++; end

    check(resp_valid, "R10", "response seen", 64'(resp_valid), 1);
    check(resp_hit == exp_hit, "R4", "hit flag", 64'(resp_hit), 64'(exp_hit));
    check(resp_rdata == (wr ? neww : oldw), wr ? "R6" : "R5", "word",
          64'(resp_rdata), 64'(wr ? neww : oldw));
    check(stall_bad == b0, "R3", "activity during stall", 64'(stall_bad - b0), 0);
    check(stall_cycles - s0 == stall, "R3", "stall cycles", 64'(stall_cycles - s0), 64'(stall));
    n_exp = exp_hit ? 0 : (exp_wb ? 2 : 1);
    check(log_n == n_exp, "R8", "transfer count", 64'(log_n), 64'(n_exp));
    if (exp_wb && log_n == 2)
      check(log_wr[0] && log_addr[0] == {16'd0, 11'(wb_line), 5'd0}, "R8",
            "write-back address", 64'(log_addr[0]), 64'({16'd0, 11'(wb_line), 5'd0}));
    if (!exp_hit && log_n == n_exp)
      check(!log_wr[n_exp-1] && log_addr[n_exp-1] == {16'd0, 11'(pl), 5'd0}, "R5",
            "fill address", 64'(log_addr[n_exp-1]), 64'({16'd0, 11'(pl), 5'd0}));
    @(negedge clk);
    check(!resp_valid, "R10", "response width", 64'(resp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    void'($urandom(32'd20240611));
    for (int l = 0; l < LINES; l++)
      for (int w = 0; w < 8; w++) begin
        bmem[l][w*32 +: 32] = init_word(l, w);
        gmem[l][w*32 +: 32] = init_word(l, w);
      end
    for (int s = 0; s < 256; s++)
      for (int k = 0; k < 4; k++) begin
        m_val[s][k] = 0; m_dty[s][k] = 0; m_tag[s][k] = 0; m_stamp[s][k] = 0;
      end
    req_valid = 0; req_write = 0; req_vaddr = 0; req_be = 0; req_wdata = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: idle state after reset
    check(req_ready && !resp_valid && !tr_valid && !mem_rd && !mem_wr, "R1", "reset outputs",
          64'({req_ready, resp_valid, tr_valid, mem_rd, mem_wr}), 64'(5'b10000));

    // R1, R5: first load misses and fills
    access(0, va_of(1, 10, 1), 4'h0, 0, 0);
    check(!resp_hit, "R1", "first access misses", 64'(resp_hit), 0);
    access(0, va_of(1, 10, 1), 4'h0, 0, 0);
    // R4: alias page 9 translates to the same physical page as page 1
    access(0, va_of(9, 10, 1), 4'h0, 0, 0);
    check(resp_hit, "R4", "alias hits", 64'(resp_hit), 1);
    // R6, R2: partial store through the alias, read back through the original
    access(1, va_of(9, 10, 1), 4'b0101, 32'hCAFEBEEF, 0);
    exp = gmem[int'(ppn_of(19'd1)) * 256 + 10][63:32];
    access(0, va_of(1, 10, 1), 4'h0, 0, 0);
    check(resp_rdata == exp && exp[23:16] == 8'hFE && exp[7:0] == 8'hEF, "R2",
          "byte lanes", 64'(resp_rdata), 64'(exp));
    // R3: held translation
    access(0, va_of(1, 10, 3), 4'h0, 0, 5);
    // R7: store miss allocates
    access(1, va_of(2, 40, 6), 4'b1100, 32'h12345678, 1);
    check(!resp_hit && log_n == 1, "R7", "store miss fills", 64'({resp_hit, 3'(log_n)}), 64'(1));
    access(0, va_of(2, 40, 6), 4'h0, 0, 0);
    exp = gmem[int'(ppn_of(19'd2)) * 256 + 40][223:192];
    check(resp_hit && resp_rdata == exp, "R7", "merged word", 64'(resp_rdata), 64'(exp));
    // R9: fill set 5, touch the oldest, then force a fifth page in
    for (int v = 0; v < 4; v++) access(0, va_of(v, 5, 0), 4'h0, 0, 0);
    access(0, va_of(0, 5, 0), 4'h0, 0, 0);
    access(0, va_of(4, 5, 0), 4'h0, 0, 0);
    access(0, va_of(0, 5, 0), 4'h0, 0, 0);
    check(resp_hit, "R9", "recently used line kept", 64'(resp_hit), 1);
    access(0, va_of(1, 5, 0), 4'h0, 0, 0);
    check(!resp_hit, "R9", "oldest line evicted", 64'(resp_hit), 0);
    // R8: dirty line is written back and its data survives
    access(1, va_of(0, 6, 2), 4'hF, 32'hA1B2C3D4, 0);
    for (int v = 1; v < 5; v++) access(0, va_of(v, 6, 0), 4'h0, 0, 0);
    access(0, va_of(0, 6, 2), 4'h0, 0, 0);
    check(resp_rdata == 32'hA1B2C3D4, "R8", "written-back data", 64'(resp_rdata), 64'h A1B2C3D4);

    // Random mix concentrated on a few sets
    for (int i = 0; i < 600; i++) begin
      int vpn, set;
      vpn = int'($urandom % 16);
      set = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 3);
      access(1'($urandom % 2), va_of(vpn, set, int'($urandom % 8)), 4'($urandom % 16),
             $urandom, int'($urandom % 3));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule